// File: doc/BRIEF.md
# Driver Fault Protection Supervisor

This block sits between the control register of a twelve-switch motor driver and the gate drivers. The switches are six high-side and six low-side. It takes the switch states the host requested, the raw fault comparator flags and the protection enable bits. From these it produces the enables that actually reach the switches, plus the latched fault bits of the status word.

Load faults act on one switch at a time. These are overcurrent, shorts, open load and underload. Each switch has its own debounce counter for each load-fault class, with a programmable terminal count in system-clock cycles. A flag only counts as a fault once it has been high on that many consecutive clock edges. Once a fault qualifies, only the switch that failed is turned off, and it stays off until the host requests a status reset.

Supply and thermal faults act on the whole block. These are undervoltage, overvoltage and overtemperature. They force every switch off for as long as they last. The requested states are kept, so the switches come back by themselves when the condition clears. Supply events remain readable as latched status.

Top module: `drv_fault_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, all latched fault bits and qualification counters are cleared. After reset with no fault present, `gate_sw` equals `req_sw` and all four diagnosis outputs are 0.
- R2: Switch index mapping: bits [HB-1:0] of `req_sw`, `gate_sw` and the per-switch flag vectors are the low-side switches, and bits [2*HB-1:HB] are the high-side switches. With no fault, each `gate_sw` bit follows its `req_sw` bit in the same cycle.
- R3: An overcurrent flag qualifies only once it has been sampled high on `oc_limit` consecutive clock edges. A low sample restarts the count from zero. A terminal count of 0 behaves like 1.
- R4: When an overcurrent qualifies while `ocp_en` is 1, only that switch's `gate_sw` bit goes to 0, starting from the cycle after the qualifying edge. It stays 0 after the flag clears, until a status reset.
- R5: `diag_oc` latches 1 on any qualified overcurrent, whatever the value of `ocp_en`. When `ocp_en` is 0, no switch is turned off by overcurrent.
- R6: An open-load or underload flag qualifies in the same way as an overcurrent flag, but against `load_limit`. When `loadp_en` is 1, only that switch is turned off and held off. `diag_load` latches 1 whatever the value of `loadp_en`.
- R7: While `uv_flag` is 1, every `gate_sw` bit is 0 in the same cycle, whatever the enable bits. `diag_supply` latches 1 from the next cycle. When the flag clears, `gate_sw` returns to the requested states with no new request.
- R8: While `ov_flag` is 1 and `ovp_en` is 1, every `gate_sw` bit is 0. When `ovp_en` is 0, overvoltage does not affect `gate_sw`. In both cases `diag_supply` latches 1.
- R9: While `tsd_flag` is 1, every `gate_sw` bit is 0. The condition is not latched and sets no diagnosis output.
- R10: `twarn_flag` latches `diag_twarn` from the next cycle and has no effect on `gate_sw`.
- R11: A one-cycle `stat_clr` pulse clears every latched per-switch shutdown and all four diagnosis bits at that edge. If a fault qualifies at the same edge, that fault is latched, because setting takes precedence over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sw | input | 2*HB | Requested switch states (low-side in the low half, high-side in the high half) |
| ocp_en | input | 1 | Enable for per-switch overcurrent and short shutdown |
| loadp_en | input | 1 | Enable for per-switch open-load and underload shutdown |
| ovp_en | input | 1 | Enable for global overvoltage lockout |
| stat_clr | input | 1 | One-cycle request to clear latched status and shutdowns |
| oc_flag | input | 2*HB | Raw overcurrent and short comparator flags, one per switch |
| load_flag | input | 2*HB | Raw open-load and underload flags, one per switch |
| uv_flag | input | 1 | Supply undervoltage comparator |
| ov_flag | input | 1 | Supply overvoltage comparator |
| tsd_flag | input | 1 | Thermal shutdown comparator |
| twarn_flag | input | 1 | Temperature prewarning comparator |
| oc_limit | input | CNT_W | Overcurrent qualification terminal count, in cycles |
| load_limit | input | CNT_W | Load-loss qualification terminal count, in cycles |
| gate_sw | output | 2*HB | Effective switch enables |
| diag_supply | output | 1 | Latched supply failure status |
| diag_load | output | 1 | Latched load-loss status |
| diag_oc | output | 1 | Latched overcurrent status |
| diag_twarn | output | 1 | Latched temperature prewarning status |

## Verification
The bench drops an overcurrent flag for one cycle just before its terminal count. A design that did not restart the count would trip a switch whose fault was never continuous. It also releases a flag after a trip, to catch a design that lets the switch recover without a status reset, and it keeps a fault active across a status reset to catch clear-over-set priority. Disabled protection paths are exercised to show that the status bit still latches while the outputs stay on. The bench also checks that outputs return after an undervoltage without any rewrite, which a design that cleared the requested states would get wrong.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // Latched status bits as they appear in the status word.
    typedef struct packed {
        logic supply_fail;
        logic load_loss;
        logic over_cur;
        logic temp_warn;
    } diag_t;

    // True when one more consecutive sample reaches the terminal count.
    function automatic logic count_reached(input logic [31:0] cnt,
                                           input logic [31:0] lim);
        return (cnt + 32'd1) >= lim;
    endfunction

endpackage

// File: rtl/fps_qualifier.sv
module fps_qualifier #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flag,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] run_len;

    assign hit = flag && fps_pkg::count_reached(32'(run_len), 32'(limit));

    always_ff @(posedge clk) begin
        if (rst || !flag)
            run_len <= '0;
        else if (!hit)
            run_len <= run_len + 1'b1;
    end
endmodule

// File: rtl/fps_class_unit.sv
module fps_class_unit #(
    parameter int N  = 12,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  flags,
    input  logic [CW-1:0] limit,
    input  logic          enable,
    input  logic          clr,
    output logic [N-1:0]  trip,
    output logic          diag
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_qual
        fps_qualifier #(.CW(CW)) u_q (
            .clk  (clk),
            .rst  (rst),
            .flag (flags[i]),
            .limit(limit),
            .hit  (hit[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trip <= '0;
            diag <= 1'b0;
        end else begin
            trip <= (trip & ~{N{clr}}) | (hit & {N{enable}});
            diag <= (diag & ~clr) | (|hit);
        end
    end
endmodule

// File: rtl/fps_global_monitor.sv
module fps_global_monitor (
    input  logic clk,
    input  logic rst,
    input  logic uv,
    input  logic ov,
    input  logic ov_en,
    input  logic tsd,
    input  logic twarn,
    input  logic clr,
    output logic all_off,
    output logic supply_fail,
    output logic temp_warn
);
    assign all_off = uv | (ov & ov_en) | tsd;

    always_ff @(posedge clk) begin
        if (rst) begin
            supply_fail <= 1'b0;
            temp_warn   <= 1'b0;
        end else begin
            supply_fail <= (supply_fail & ~clr) | uv | ov;
            temp_warn   <= (temp_warn & ~clr) | twarn;
        end
    end
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
    parameter int HB    = 6,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*HB-1:0]     req_sw,
    input  logic                ocp_en,
    input  logic                loadp_en,
    input  logic                ovp_en,
    input  logic                stat_clr,
    input  logic [2*HB-1:0]     oc_flag,
    input  logic [2*HB-1:0]     load_flag,
    input  logic                uv_flag,
    input  logic                ov_flag,
    input  logic                tsd_flag,
    input  logic                twarn_flag,
    input  logic [CNT_W-1:0]    oc_limit,
    input  logic [CNT_W-1:0]    load_limit,
    output logic [2*HB-1:0]     gate_sw,
    output logic                diag_supply,
    output logic                diag_load,
    output logic                diag_oc,
    output logic                diag_twarn
);
    localparam int SW = 2 * HB;

    logic [SW-1:0] trip_oc, trip_load;
    logic          all_off;
    fps_pkg::diag_t diag;

    fps_class_unit #(.N(SW), .CW(CNT_W)) u_oc (
        .clk   (clk),
        .rst   (rst),
        .flags (oc_flag),
        .limit (oc_limit),
        .enable(ocp_en),
        .clr   (stat_clr),
        .trip  (trip_oc),
        .diag  (diag.over_cur)
    );

    fps_class_unit #(.N(SW), .CW(CNT_W)) u_load (
        .clk   (clk),
        .rst   (rst),
        .flags (load_flag),
        .limit (load_limit),
        .enable(loadp_en),
        .clr   (stat_clr),
        .trip  (trip_load),
        .diag  (diag.load_loss)
    );

    fps_global_monitor u_glob (
        .clk        (clk),
        .rst        (rst),
        .uv         (uv_flag),
        .ov         (ov_flag),
        .ov_en      (ovp_en),
        .tsd        (tsd_flag),
        .twarn      (twarn_flag),
        .clr        (stat_clr),
        .all_off    (all_off),
        .supply_fail(diag.supply_fail),
        .temp_warn  (diag.temp_warn)
    );

    assign gate_sw     = req_sw & ~(trip_oc | trip_load) & {SW{~all_off}};
    assign diag_supply = diag.supply_fail;
    assign diag_load   = diag.load_loss;
    assign diag_oc     = diag.over_cur;
    assign diag_twarn  = diag.temp_warn;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int SW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] req_sw,
    input logic [SW-1:0] gate_sw,
    input logic          uv_flag,
    input logic          ov_flag,
    input logic          ovp_en,
    input logic          tsd_flag,
    input logic          twarn_flag,
    input logic          stat_clr,
    input logic          diag_supply,
    input logic          diag_oc,
    input logic          diag_twarn
);
    // R2: no switch is ever enabled that was not requested
    p_gate_subset_r2: assert property (@(posedge clk) disable iff (rst)
        (gate_sw & ~req_sw) == '0);

    // R7: undervoltage forces every switch off
    p_uv_all_off_r7: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> gate_sw == '0);

    // R7: supply failure is latched on the next edge
    p_uv_latch_r7: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> diag_supply);

    // R8: enabled overvoltage forces every switch off
    p_ov_all_off_r8: assert property (@(posedge clk) disable iff (rst)
        (ov_flag && ovp_en) |-> gate_sw == '0);

    // R9: thermal shutdown forces every switch off
    p_tsd_all_off_r9: assert property (@(posedge clk) disable iff (rst)
        tsd_flag |-> gate_sw == '0);

    // R10: prewarning is latched on the next edge
    p_twarn_latch_r10: assert property (@(posedge clk) disable iff (rst)
        twarn_flag |=> diag_twarn);

    // R11: latched overcurrent status holds until a status reset
    p_oc_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (diag_oc && !stat_clr) |=> diag_oc);
endmodule

bind drv_fault_supervisor fps_checker #(.SW(2 * HB)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_sw     (req_sw),
    .gate_sw    (gate_sw),
    .uv_flag    (uv_flag),
    .ov_flag    (ov_flag),
    .ovp_en     (ovp_en),
    .tsd_flag   (tsd_flag),
    .twarn_flag (twarn_flag),
    .stat_clr   (stat_clr),
    .diag_supply(diag_supply),
    .diag_oc    (diag_oc),
    .diag_twarn (diag_twarn)
);

// File: tb/tb_drv_fault_supervisor.sv
`timescale 1ns/1ps
module tb_drv_fault_supervisor;
    localparam int HB = 6;
    localparam int SW = 2 * HB;
    localparam int CW = 16;
    localparam int OC_LIM = 8;
    localparam int LD_LIM = 40;

    logic clk = 1'b0;
    logic rst;
    logic [SW-1:0] req_sw, oc_flag, load_flag, gate_sw;
    logic ocp_en, loadp_en, ovp_en, stat_clr;
    logic uv_flag, ov_flag, tsd_flag, twarn_flag;
    logic [CW-1:0] oc_limit, load_limit;
    logic diag_supply, diag_load, diag_oc, diag_twarn;

    always #10 clk = ~clk;

    drv_fault_supervisor #(.HB(HB), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .req_sw(req_sw), .ocp_en(ocp_en),
        .loadp_en(loadp_en), .ovp_en(ovp_en), .stat_clr(stat_clr),
        .oc_flag(oc_flag), .load_flag(load_flag), .uv_flag(uv_flag),
        .ov_flag(ov_flag), .tsd_flag(tsd_flag), .twarn_flag(twarn_flag),
        .oc_limit(oc_limit), .load_limit(load_limit), .gate_sw(gate_sw),
        .diag_supply(diag_supply), .diag_load(diag_load),
        .diag_oc(diag_oc), .diag_twarn(diag_twarn)
    );

    // Behavioural reference state
    int oc_run[SW];
    int ld_run[SW];
    bit [SW-1:0] m_off_oc, m_off_ld;
    bit m_sup, m_ld, m_oc, m_tw;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";
    int cycles = 0;
    bit done = 0;

    always @(posedge clk) begin
        bit [SW-1:0] q_oc, q_ld;
        cycles++;
        if (rst) begin
            for (int i = 0; i < SW; i++) begin oc_run[i] = 0; ld_run[i] = 0; end
            m_off_oc = '0; m_off_ld = '0;
            m_sup = 0; m_ld = 0; m_oc = 0; m_tw = 0;
        end else begin
            for (int i = 0; i < SW; i++) begin
                q_oc[i] = oc_flag[i] && (oc_run[i] + 1 >= int'(oc_limit));
                q_ld[i] = load_flag[i] && (ld_run[i] + 1 >= int'(load_limit));
                if (!oc_flag[i]) oc_run[i] = 0; else if (!q_oc[i]) oc_run[i]++;
                if (!load_flag[i]) ld_run[i] = 0; else if (!q_ld[i]) ld_run[i]++;
            end
            if (stat_clr) begin
                m_off_oc = '0; m_off_ld = '0;
                m_sup = 0; m_ld = 0; m_oc = 0; m_tw = 0;
            end
            if (ocp_en) m_off_oc |= q_oc;
            if (loadp_en) m_off_ld |= q_ld;
            if (|q_oc) m_oc = 1;
            if (|q_ld) m_ld = 1;
            if (uv_flag || ov_flag) m_sup = 1;
            if (twarn_flag) m_tw = 1;
        end
    end

    function automatic bit [SW-1:0] exp_gate();
        if (uv_flag || (ov_flag && ovp_en) || tsd_flag) return '0;
        return req_sw & ~(m_off_oc | m_off_ld);
    endfunction

    task automatic compare();
        bit [3:0] got_d, exp_d;
        n_cmp++;
        if (gate_sw !== exp_gate()) begin
            n_bad++;
            $display("FAIL %s gate_sw got %h expected %h at cycle %0d",
                     cur_req, gate_sw, exp_gate(), cycles);
        end
        got_d = {diag_supply, diag_load, diag_oc, diag_twarn};
        exp_d = {m_sup, m_ld, m_oc, m_tw};
        n_cmp++;
        if (got_d !== exp_d) begin
            n_bad++;
            $display("FAIL %s diag got %b expected %b at cycle %0d",
                     cur_req, got_d, exp_d, cycles);
        end
    endtask

    task automatic check(input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (!rst) compare();
        end
    endtask

    task automatic clr_pulse();
        stat_clr = 1; tick(1); stat_clr = 0;
    endtask

    always @(negedge clk) begin
        if (!done && cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; req_sw = '0; oc_flag = '0; load_flag = '0;
        ocp_en = 1; loadp_en = 1; ovp_en = 1; stat_clr = 0;
        uv_flag = 0; ov_flag = 0; tsd_flag = 0; twarn_flag = 0;
        oc_limit = CW'(OC_LIM); load_limit = CW'(LD_LIM);
        tick(3);
        rst = 0;
        cur_req = "R1"; tick(2);
        check("R1 reset gate", 32'(gate_sw), 32'h0);
        check("R1 reset diag", {28'd0, diag_supply, diag_load, diag_oc, diag_twarn}, 32'h0);

        cur_req = "R2";
        req_sw = 12'hFFF; tick(1);
        check("R2 all on", 32'(gate_sw), 32'hFFF);
        req_sw = 12'hA5C; tick(1);
        check("R2 pattern", 32'(gate_sw), 32'hA5C);
        req_sw = 12'hFFF; tick(2);

        cur_req = "R3";
        oc_flag[2] = 1; tick(OC_LIM - 1);
        oc_flag[2] = 0; tick(1);
        oc_flag[2] = 1; tick(OC_LIM - 1);
        check("R3 restart no trip", 32'(gate_sw), 32'hFFF);
        tick(1);
        cur_req = "R4";
        check("R4 one switch off", 32'(gate_sw), 32'hFFB);
        oc_flag[2] = 0; tick(5);
        check("R4 held after flag drop", 32'(gate_sw), 32'hFFB);
        cur_req = "R11"; clr_pulse();
        check("R11 cleared", 32'(gate_sw), 32'hFFF);
        check("R11 diag cleared", 32'(diag_oc), 32'h0);

        cur_req = "R3"; oc_limit = 0;
        oc_flag[4] = 1; tick(1);
        check("R3 limit zero trips at once", 32'(gate_sw), 32'hFEF);
        oc_flag[4] = 0; oc_limit = CW'(OC_LIM); clr_pulse();

        cur_req = "R5"; ocp_en = 0;
        oc_flag[9] = 1; tick(OC_LIM + 10);
        check("R5 no shutdown", 32'(gate_sw), 32'hFFF);
        check("R5 diag set", 32'(diag_oc), 32'h1);
        oc_flag[9] = 0; ocp_en = 1; clr_pulse();

        cur_req = "R6";
        load_flag[7] = 1; tick(LD_LIM);
        check("R6 load trip", 32'(gate_sw), 32'hF7F);
        check("R6 diag", 32'(diag_load), 32'h1);
        load_flag[7] = 0; tick(3);
        check("R6 held", 32'(gate_sw), 32'hF7F);
        clr_pulse();
        loadp_en = 0; load_flag[1] = 1; tick(LD_LIM + 5);
        check("R6 disabled no trip", 32'(gate_sw), 32'hFFF);
        check("R6 disabled diag", 32'(diag_load), 32'h1);
        load_flag[1] = 0; loadp_en = 1; clr_pulse();

        cur_req = "R7"; req_sw = 12'h3C3; ovp_en = 0; ocp_en = 0;
        uv_flag = 1; tick(1);
        check("R7 all off", 32'(gate_sw), 32'h0);
        tick(4); uv_flag = 0; tick(1);
        check("R7 resume", 32'(gate_sw), 32'h3C3);
        check("R7 diag stored", 32'(diag_supply), 32'h1);
        ocp_en = 1; clr_pulse();

        cur_req = "R8"; ovp_en = 1; ov_flag = 1; tick(3);
        check("R8 all off", 32'(gate_sw), 32'h0);
        ovp_en = 0; tick(2);
        check("R8 disabled on", 32'(gate_sw), 32'h3C3);
        check("R8 diag", 32'(diag_supply), 32'h1);
        ov_flag = 0; ovp_en = 1; clr_pulse();

        cur_req = "R9"; tsd_flag = 1; tick(3);
        check("R9 all off", 32'(gate_sw), 32'h0);
        check("R9 no diag", {28'd0, diag_supply, diag_load, diag_oc, diag_twarn}, 32'h0);
        tsd_flag = 0; tick(1);
        check("R9 resume", 32'(gate_sw), 32'h3C3);

        cur_req = "R10"; twarn_flag = 1; tick(1); twarn_flag = 0; tick(3);
        check("R10 gates unaffected", 32'(gate_sw), 32'h3C3);
        check("R10 diag", 32'(diag_twarn), 32'h1);
        clr_pulse();

        cur_req = "R11"; oc_flag[0] = 1; tick(OC_LIM + 2);
        check("R11 pre trip", 32'(gate_sw), 32'h3C2);
        clr_pulse();
        check("R11 set wins", 32'(gate_sw), 32'h3C2);
        check("R11 diag set wins", 32'(diag_oc), 32'h1);
        oc_flag[0] = 0; tick(1); clr_pulse();
        check("R11 final clear", 32'(gate_sw), 32'h3C3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule